// File: doc/BRIEF.md
# Fixed-Latency One-Shot Step Sequencer

This block sequences a component whose latency is fixed at `LATENCY` cycles. The caller pulses `start` for a single cycle to launch a run. The block then walks an internal step counter through steps 1 to `LATENCY-1` without any further condition and returns to idle. The result of the run is due `LATENCY` cycles after the launch cycle. Step 0 has no stored state of its own: it is the launching `start` pulse, used combinationally in the same cycle. Because of this, every enable that includes step 0 is the OR of the launch with a counter comparison.

The sequencer drives a set of single-step strobes and a set of step-range enables. Each strobe and each range is chosen by parameter. A small demo datapath, a pipelined multiplier, is wired to the sequencer. The multiplier's own start strobe fires at step 1. Its operands are gated by an enable that covers steps 0 to `LATENCY-1`. Only one run is in flight at a time: a `start` that arrives during a run is ignored. The demo datapath needs `LATENCY` of at least 3.

Top module: `fls_seq_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), and afterwards with `start` low, `step` is 0 and `busy`, `done`, `mul_go`, `mul_opnd_en`, `product_valid`, every `strobe_en` bit and every `range_en` bit are low. `product` is reset to 0.
- R2: A `start` pulse while `step` is 0 is a launch. In that same cycle `busy` is high, `step` reads 0, and every enable whose step set includes step 0 is high.
- R3: After a launch, `step` reads 1, 2, ..., `LATENCY-1` on consecutive cycles, whatever `start` does, and then returns to 0. While idle with `start` low, `step` stays at 0.
- R4: `done` is high exactly in the one cycle where `step` equals `LATENCY-1`.
- R5: `busy` is high from the launch cycle through the cycle with step `LATENCY-1`, and low in idle cycles without a launch.
- R6: `strobe_en[k]` is high only in the step held in 8-bit field k (bits 8k+7..8k) of `STROBE_AT`. A field value of 0 means the launch cycle.
- R7: `range_en[k]` is high in the steps from field k of `RANGE_LO` up to, but not including, field k of `RANGE_HI` (8-bit fields at bits 8k+7..8k). Step 0 counts as the launch cycle.
- R8: A `start` that arrives while `step` is not 0 is ignored. It changes neither the step sequence nor any enable, and it produces no step-0 enables.
- R9: A launch in the cycle right after step `LATENCY-1` starts a new run with no idle cycle in between.
- R10: `mul_go` is high only at step 1. `mul_opnd_en` is high in steps 0 to `LATENCY-1` of a run.
- R11: `product_valid` pulses exactly `LATENCY` cycles after the launch cycle. In that cycle `product` equals `a*b` as held during the run, and it keeps that value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse |
| a | input | DATA_W | Multiplier operand, held during a run |
| b | input | DATA_W | Multiplier operand, held during a run |
| busy | output | 1 | A run is in progress, including the launch cycle |
| step | output | cnt_width(LATENCY) | Current step counter |
| done | output | 1 | Last step of the run |
| strobe_en | output | NUM_STROBE | Single-step enables |
| range_en | output | NUM_RANGE | Step-range enables |
| mul_go | output | 1 | Start strobe given to the demo multiplier |
| mul_opnd_en | output | 1 | Operand gate of the demo multiplier |
| product | output | 2*DATA_W | Last multiplier result |
| product_valid | output | 1 | Pulse when `product` is updated |

## Verification
The assertions take for granted that the operands `a` and `b` do not change while `step` is not 0. They may change only in an idle or launch cycle. The product check relies on this, because the multiplier samples its operands at step 1 rather than at launch. The stimulus therefore loads new operands only together with a launch pulse and keeps them fixed through each run, including runs that receive stray mid-run `start` pulses. The only exception is a back-to-back relaunch, which coincides with the previous run's idle step.

// File: rtl/fls_pkg.sv
package fls_pkg;

  // Width of the step counter: at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Single-step hit: step 0 is the launch itself, other steps come from the counter.
  function automatic logic step_hit(input logic launch, input int unsigned cnt,
                                    input int unsigned at);
    if (at == 0) return launch;
    return (cnt == at);
  endfunction

  // Half-open step range [lo, hi): step 0 is forwarded from the launch.
  function automatic logic range_hit(input logic launch, input int unsigned cnt,
                                     input int unsigned lo, input int unsigned hi);
    int unsigned first;
    logic        from_launch;
    from_launch = (lo == 0) && (hi > 0) && launch;
    first       = (lo == 0) ? 1 : lo;
    return from_launch || ((cnt >= first) && (cnt < hi));
  endfunction

endpackage

// File: rtl/fls_step_counter.sv
module fls_step_counter import fls_pkg::*; #(
  parameter int unsigned LATENCY = 4,
  localparam int unsigned CW = cnt_width(LATENCY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          launch,
  output logic          busy,
  output logic          last
);
  localparam logic [CW-1:0] LAST_STEP = CW'(LATENCY - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          idle;

  assign idle   = (cnt_q == '0);
  assign launch = start && idle;
  assign last   = (cnt_q == LAST_STEP);
  assign busy   = launch || !idle;
  assign cnt    = cnt_q;

  always_comb begin
    if (idle)      cnt_d = launch ? CW'(1) : '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fls_step_decode.sv
module fls_step_decode import fls_pkg::*; #(
  parameter int unsigned CW         = 2,
  parameter int unsigned NUM_STROBE = 2,
  parameter int unsigned NUM_RANGE  = 2,
  parameter logic [NUM_STROBE*8-1:0] STROBE_AT = '0,
  parameter logic [NUM_RANGE*8-1:0]  RANGE_LO  = '0,
  parameter logic [NUM_RANGE*8-1:0]  RANGE_HI  = '0
) (
  input  logic                  launch,
  input  logic [CW-1:0]         cnt,
  output logic [NUM_STROBE-1:0] strobe_en,
  output logic [NUM_RANGE-1:0]  range_en
);
  int unsigned cnt_i;
  assign cnt_i = 32'(cnt);

  for (genvar k = 0; k < NUM_STROBE; k++) begin : g_strobe
    localparam int unsigned AT = int'(STROBE_AT[k*8 +: 8]);
    always_comb strobe_en[k] = step_hit(launch, cnt_i, AT);
  end

  for (genvar k = 0; k < NUM_RANGE; k++) begin : g_range
    localparam int unsigned LO = int'(RANGE_LO[k*8 +: 8]);
    localparam int unsigned HI = int'(RANGE_HI[k*8 +: 8]);
    always_comb range_en[k] = range_hit(launch, cnt_i, LO, HI);
  end
endmodule

// File: rtl/fls_demo_mul.sv
module fls_demo_mul #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic [2*DATA_W-1:0] res,
  output logic                res_vld
);
  localparam int unsigned PW = 2 * DATA_W;

  logic [PW-1:0] pipe_q [STAGES];
  logic          vld_q  [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_q[0] <= '0;
          vld_q[0]  <= 1'b0;
        end else begin
          pipe_q[0] <= PW'(opa) * PW'(opb);
          vld_q[0]  <= go;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_q[s] <= '0;
          vld_q[s]  <= 1'b0;
        end else begin
          pipe_q[s] <= pipe_q[s-1];
          vld_q[s]  <= vld_q[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= vld_q[STAGES-1];
      if (vld_q[STAGES-1]) res <= pipe_q[STAGES-1];
    end
  end
endmodule

// File: rtl/fls_seq_top.sv
module fls_seq_top import fls_pkg::*; #(
  parameter int unsigned LATENCY    = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_STROBE = 2,
  parameter int unsigned NUM_RANGE  = 2,
  parameter logic [NUM_STROBE*8-1:0] STROBE_AT = {8'd3, 8'd0},
  parameter logic [NUM_RANGE*8-1:0]  RANGE_LO  = {8'd1, 8'd0},
  parameter logic [NUM_RANGE*8-1:0]  RANGE_HI  = {8'd3, 8'd4}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [DATA_W-1:0]            a,
  input  logic [DATA_W-1:0]            b,
  output logic                         busy,
  output logic [cnt_width(LATENCY)-1:0] step,
  output logic                         done,
  output logic [NUM_STROBE-1:0]        strobe_en,
  output logic [NUM_RANGE-1:0]         range_en,
  output logic                         mul_go,
  output logic                         mul_opnd_en,
  output logic [2*DATA_W-1:0]          product,
  output logic                         product_valid
);
  localparam int unsigned CW         = cnt_width(LATENCY);
  localparam int unsigned MUL_STAGES = LATENCY - 2;

  logic          launch;
  logic [CW-1:0] cnt;
  logic [DATA_W-1:0] opa_g;
  logic [DATA_W-1:0] opb_g;

  fls_step_counter #(.LATENCY(LATENCY)) u_cnt (
    .clk(clk), .rst(rst), .start(start),
    .cnt(cnt), .launch(launch), .busy(busy), .last(done)
  );

  fls_step_decode #(
    .CW(CW), .NUM_STROBE(NUM_STROBE), .NUM_RANGE(NUM_RANGE),
    .STROBE_AT(STROBE_AT), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) u_dec (
    .launch(launch), .cnt(cnt), .strobe_en(strobe_en), .range_en(range_en)
  );

  // Demo-side qualifiers: go at step 1, operands over the whole run.
  assign mul_go      = step_hit(launch, 32'(cnt), 1);
  assign mul_opnd_en = range_hit(launch, 32'(cnt), 0, LATENCY);
  assign opa_g       = mul_opnd_en ? a : '0;
  assign opb_g       = mul_opnd_en ? b : '0;
  assign step        = cnt;

  fls_demo_mul #(.DATA_W(DATA_W), .STAGES(MUL_STAGES)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .opa(opa_g), .opb(opb_g),
    .res(product), .res_vld(product_valid)
  );
endmodule

// File: rtl/fls_seq_chk.sv
module fls_seq_chk #(
  parameter int unsigned LATENCY = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CW      = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [DATA_W-1:0]   a,
  input logic [DATA_W-1:0]   b,
  input logic                busy,
  input logic [CW-1:0]       step,
  input logic                done,
  input logic                mul_go,
  input logic                mul_opnd_en,
  input logic [2*DATA_W-1:0] product,
  input logic                product_valid
);
  localparam logic [CW-1:0] LAST_STEP = CW'(LATENCY - 1);

  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (step == '0 && !start) |=> step == '0);                                   // R3
  AST_LAUNCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (step == '0 && start) |=> step == CW'(1));                                 // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step != '0 && step != LAST_STEP) |=> step == $past(step) + CW'(1));       // R8
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    done |=> (step == '0 && !done));                                          // R4
  AST_BUSY_RUN: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |-> busy);                                                   // R5
  AST_GO_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    mul_go |-> (mul_opnd_en && busy && !done));                               // R10
  AST_OPND_HELD: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |-> ($stable(a) && $stable(b)));                             // R11
  AST_PV_IDLE: assert property (@(posedge clk) disable iff (rst)
    product_valid |-> step == '0);                                            // R11
  AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    product_valid |-> product == ((2*DATA_W)'($past(a)) * (2*DATA_W)'($past(b)))); // R11
endmodule

bind fls_seq_top fls_seq_chk #(.LATENCY(LATENCY), .DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .busy(busy), .step(step),
  .done(done), .mul_go(mul_go), .mul_opnd_en(mul_opnd_en), .product(product),
  .product_valid(product_valid)
);

// File: tb/sim_fls_seq_top.sv
module sim_fls_seq_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int STB_AT [2] = '{0, 3};
  localparam int RG_LO  [2] = '{0, 1};
  localparam int RG_HI  [2] = '{4, 3};

  typedef struct {
    string       tag;
    logic        busy;
    int          step;
    logic        done;
    logic [1:0]  stb;
    logic [1:0]  rng;
    logic        go;
    logic        opnd;
    logic        pv;
    logic [15:0] prod;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done, mul_go, mul_opnd_en, product_valid;
  logic [1:0] step;
  logic [1:0] strobe_en, range_en;
  logic [15:0] product;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];

  int rc = 0, pcnt = 0;
  logic [15:0] prod_exp = '0, pend = '0;

  always #5 clk = ~clk;

  fls_seq_top u0 (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .busy(busy), .step(step),
    .done(done), .strobe_en(strobe_en), .range_en(range_en), .mul_go(mul_go),
    .mul_opnd_en(mul_opnd_en), .product(product), .product_valid(product_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic cyc(input bit r, input bit s, input logic [W-1:0] va,
                     input logic [W-1:0] vb, input string tag);
    exp_t e;
    int   pos;
    bit   lch;
    @(negedge clk);
    rst = r; start = s; a = va; b = vb;
    if (!r && pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) prod_exp = pend;
    end
    lch = !r && s && (rc == 0);
    pos = lch ? 0 : ((!r && rc != 0) ? rc : -1);
    e.tag  = tag;
    e.busy = (pos >= 0);
    e.step = r ? 0 : rc;
    e.done = (pos == N - 1);
    for (int k = 0; k < 2; k++) begin
      e.stb[k] = (pos == STB_AT[k]);
      e.rng[k] = (pos >= RG_LO[k]) && (pos < RG_HI[k]) && (pos >= 0);
    end
    e.go   = (pos == 1);
    e.opnd = (pos >= 0);
    e.pv   = !r && (pcnt == 0) && (prod_exp === pend) && pv_now;
    e.prod = r ? 16'h0 : prod_exp;
    q.push_back(e);
    if (r) begin
      rc = 0; pcnt = 0; prod_exp = '0; pend = '0;
    end else if (lch) begin
      rc = 1; pcnt = N; pend = 16'(va) * 16'(vb);
    end else if (rc != 0) begin
      rc = (rc == N - 1) ? 0 : rc + 1;
    end
    pv_now = 0;
  endtask

  bit pv_now = 0;
  // Marks the cycle where the countdown reaches zero, set before the push.
  always @(negedge clk) if (!rst && pcnt == 1) pv_now = 1;

  // Monitor: pops one expectation per cycle and compares away from the edge.
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(busy == e.busy, e.tag == "" ? "R5" : e.tag, "busy", busy, e.busy);
      chk(int'(step) == e.step, e.tag == "" ? "R3" : e.tag, "step", step, e.step);
      chk(done == e.done, "R4", "done", done, e.done);
      chk(strobe_en == e.stb, e.tag == "" ? "R6" : e.tag, "strobe_en", strobe_en, e.stb);
      chk(range_en == e.rng, e.tag == "" ? "R7" : e.tag, "range_en", range_en, e.rng);
      chk(mul_go == e.go && mul_opnd_en == e.opnd, "R10", "go/opnd",
          {mul_go, mul_opnd_en}, {e.go, e.opnd});
      chk(product_valid == e.pv, "R11", "product_valid", product_valid, e.pv);
      chk(product == e.prod, "R11", "product", product, e.prod);
    end
  end

  task automatic run(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
    cyc(0, 1, va, vb, tag);
    for (int i = 1; i < N; i++) cyc(0, 0, va, vb, "");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'h00, 8'h00, "R1");
    for (int i = 0; i < 2; i++) cyc(0, 0, 8'h00, 8'h00, "R1");
    run(8'd7, 8'd9, "R2");
    for (int i = 0; i < 2; i++) cyc(0, 0, 8'd7, 8'd9, "");
    run(8'd255, 8'd255, "R2");
    run(8'd3, 8'd5, "R9");
    cyc(0, 0, 8'd3, 8'd5, "");
    // Stray starts inside a run are ignored.
    cyc(0, 1, 8'd12, 8'd11, "R2");
    cyc(0, 1, 8'd12, 8'd11, "R8");
    cyc(0, 0, 8'd12, 8'd11, "");
    cyc(0, 1, 8'd12, 8'd11, "R8");
    for (int i = 0; i < 2; i++) cyc(0, 0, 8'd12, 8'd11, "");
    run(8'd0, 8'd200, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'd0, 8'd200, "");
    @(negedge clk);
    #4;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule